// File: doc/BRIEF.md
# Bytecode Operand Stack Executor

This block is a small stack-machine core. After reset it fetches a byte stream from an instruction memory port, one byte per clock, starting at address 0. It executes a small set of integer stack instructions on an internal operand stack whose slots are one word wide. Instructions are one, two or three bytes long.

The core supports three kinds of instruction. The first pushes a small constant. The second pushes a signed 8-bit or 16-bit immediate, widened to a full word by sign extension. The third is an add that pops two words and pushes their sum. The memory port is read combinationally: the byte at `imem_addr` must appear on `imem_data` in the same cycle.

The core shows its top of stack and its stack depth at all times. It stops on an unknown opcode, on a push into a full stack, or on an add with fewer than two entries. The last two of these also raise `error`. Once stopped, it stays frozen until the next reset.

Top module: `bc_stack_core`

## Requirements
- R1: While `rst_n` is low, depth is 0, `tos` is 0, `halted` is 0, `error` is 0 and `imem_addr` is 0.
- R2: Opcodes 0x03 to 0x08 are one byte long and push the constants 0 to 5. Opcode 0x03 pushes 0, and each following opcode pushes the next integer.
- R3: Opcode 0x10 is two bytes long. The second byte is a signed 8-bit value, and it is sign-extended to a full word and pushed.
- R4: Opcode 0x11 is three bytes long. Bytes two and three form a signed 16-bit value, high byte first. It is sign-extended and pushed.
- R5: Opcode 0x60 pops the top two entries and pushes their sum modulo 2^WORD_W, so depth drops by one. There is no overflow indication.
- R6: The core consumes exactly one instruction byte per cycle, so an instruction of n bytes takes n cycles. The program counter then advances by n.
- R7: Any other opcode sets `halted` with `error` low. `imem_addr` stays on that opcode. It is reached one cycle after the bytes that precede it.
- R8: A push opcode seen while depth equals DEPTH (16) sets `halted` and `error` in its first cycle. The stack is left unchanged and `imem_addr` stays on that opcode.
- R9: Opcode 0x60 seen with depth below 2 sets `halted` and `error` in its first cycle. The stack is left unchanged.
- R10: Once `halted` is set, `tos`, `depth`, `imem_addr`, `halted` and `error` hold their values until reset.
- R11: `tos` reads 0 whenever the depth is 0.
- R12: The program 0x06, 0x10 0x06, 0x60, 0x11 0x00 0x82, 0x60 leaves depth 1 and 139 on top of the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| imem_addr | output | AW | Address of the instruction byte being read |
| imem_data | input | 8 | Instruction byte at `imem_addr`, same cycle |
| tos | output | WORD_W | Top-of-stack word, 0 when the stack is empty |
| depth | output | $clog2(DEPTH+1) | Number of live stack entries |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Stop was caused by a stack overflow or underflow |

## Verification
The bench builds the core with its default parameters: a 16-entry stack, 32-bit words and an 8-bit address. With a 16-entry stack, a run of seventeen pushes reaches the overflow check. The 32-bit word puts sign extension of both immediate widths and add wraparound at a visible boundary. The 256-byte address space holds random programs of up to forty instructions, which mix pushes and adds into overflow, underflow and clean stops.

// File: rtl/bc_stack_core.sv
module bc_stack_core #(
  parameter int DEPTH  = 16,
  parameter int AW     = 8,
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [AW-1:0]                imem_addr,
  input  logic [7:0]                   imem_data,
  output logic [WORD_W-1:0]            tos,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         halted,
  output logic                         error
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] OP_C0  = 8'h03;
  localparam logic [7:0] OP_C5  = 8'h08;
  localparam logic [7:0] OP_BP  = 8'h10;
  localparam logic [7:0] OP_SP  = 8'h11;
  localparam logic [7:0] OP_ADD = 8'h60;

  typedef enum logic [1:0] {PH_OP = 2'd0, PH_B1 = 2'd1, PH_B2 = 2'd2} phase_t;

  logic [WORD_W-1:0] stk [DEPTH];
  logic [AW-1:0]     pc;
  logic [DW-1:0]     sp;
  phase_t            ph;
  logic              wide_imm;
  logic [7:0]        hi_byte;
  logic              halt_q, err_q;

  wire is_const   = (imem_data >= OP_C0) && (imem_data <= OP_C5);
  wire is_push_op = is_const || (imem_data == OP_BP) || (imem_data == OP_SP);
  wire full       = (sp == DW'(DEPTH));
  wire [IW-1:0] top_i = sp[IW-1:0] - 1'b1;
  wire [IW-1:0] sec_i = sp[IW-1:0] - 2'd2;
  wire [IW-1:0] put_i = sp[IW-1:0];
  wire do_add = !halt_q && (ph == PH_OP) && (imem_data == OP_ADD) && (sp >= DW'(2));

  logic              do_push;
  logic [WORD_W-1:0] push_val;

  always_comb begin
    do_push  = 1'b0;
    push_val = '0;
    if (!halt_q) begin
      case (ph)
        PH_OP: if (is_const && !full) begin
          do_push  = 1'b1;
          push_val = WORD_W'(imem_data - OP_C0);
        end
        PH_B1: if (!wide_imm) begin
          do_push  = 1'b1;
          push_val = {{(WORD_W-8){imem_data[7]}}, imem_data};
        end
        PH_B2: begin
          do_push  = 1'b1;
          push_val = {{(WORD_W-16){hi_byte[7]}}, hi_byte, imem_data};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)
      stk[put_i] <= push_val;
    else if (do_add)
      stk[sec_i] <= stk[top_i] + stk[sec_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      sp       <= '0;
      ph       <= PH_OP;
      wide_imm <= 1'b0;
      hi_byte  <= '0;
      halt_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (!halt_q) begin
      case (ph)
        PH_OP: begin
          if (is_push_op && full) begin
            halt_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (is_const) begin
            sp <= sp + 1'b1;
            pc <= pc + 1'b1;
          end else if (imem_data == OP_BP) begin
            ph       <= PH_B1;
            wide_imm <= 1'b0;
          end else if (imem_data == OP_SP) begin
            ph       <= PH_B1;
            wide_imm <= 1'b1;
          end else if (imem_data == OP_ADD) begin
            if (sp < DW'(2)) begin
              halt_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              sp <= sp - 1'b1;
              pc <= pc + 1'b1;
            end
          end else begin
            halt_q <= 1'b1;
          end
        end
        PH_B1: begin
          if (wide_imm) begin
            hi_byte <= imem_data;
            ph      <= PH_B2;
          end else begin
            sp <= sp + 1'b1;
            pc <= pc + AW'(2);
            ph <= PH_OP;
          end
        end
        default: begin
          sp <= sp + 1'b1;
          pc <= pc + AW'(3);
          ph <= PH_OP;
        end
      endcase
    end
  end

  assign imem_addr = pc + AW'(ph);
  assign tos       = (sp == '0) ? '0 : stk[top_i];
  assign depth     = sp;
  assign halted    = halt_q;
  assign error     = err_q;

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= DW'(DEPTH));

  assert_error_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> halt_q);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q && $stable(sp) && $stable(imem_addr) && $stable(err_q) && $stable(tos));

  assert_add_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && ph == PH_OP && imem_data == OP_ADD && sp >= DW'(2)) |=> (sp == $past(sp) - 1'b1));

  assert_full_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && ph == PH_OP && is_push_op && full) |=> (halt_q && err_q && $stable(sp)));

  assert_empty_tos_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp == '0) |-> (tos == '0));
endmodule

// File: tb/bc_stack_core_test.sv
`timescale 1ns/1ps
module bc_stack_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [7:0]  imem_data;
  logic [31:0] tos;
  logic [4:0]  depth;
  logic        halted, error;
  logic [7:0]  mem [256];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;
  assign imem_data = mem[imem_addr];

  bc_stack_core #(.DEPTH(16), .AW(8), .WORD_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .tos(tos), .depth(depth), .halted(halted), .error(error));

  logic [31:0] e_tos;
  int          e_depth, e_pc;
  logic        e_err;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx8(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

  task automatic model_run();
    logic [31:0] ms [16];
    int d = 0;
    int pc = 0;
    logic [7:0] op;
    e_err = 1'b0;
    for (int step = 0; step < 300; step++) begin
      op = mem[pc[7:0]];
      if (op >= 8'h03 && op <= 8'h08) begin
        if (d == 16) begin e_err = 1'b1; break; end
        ms[d] = 32'(op) - 32'd3; d++; pc += 1;
      end else if (op == 8'h10) begin
        if (d == 16) begin e_err = 1'b1; break; end
        ms[d] = sx8(mem[(pc+1) & 255]); d++; pc += 2;
      end else if (op == 8'h11) begin
        if (d == 16) begin e_err = 1'b1; break; end
        ms[d] = {{16{mem[(pc+1) & 255][7]}}, mem[(pc+1) & 255], mem[(pc+2) & 255]};
        d++; pc += 3;
      end else if (op == 8'h60) begin
        if (d < 2) begin e_err = 1'b1; break; end
        ms[d-2] = ms[d-2] + ms[d-1]; d--; pc += 1;
      end else break;
    end
    e_depth = d;
    e_pc    = pc;
    e_tos   = (d == 0) ? 32'd0 : ms[d-1];
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  task automatic run_prog(input string tag);
    int cyc = 0;
    logic [31:0] h_tos;
    logic [7:0]  h_addr;
    logic [4:0]  h_depth;
    model_run();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({tag, " R1 reset depth"}, 32'(depth), 32'd0);
    chk({tag, " R1 reset halted"}, 32'(halted), 32'd0);
    chk({tag, " R1 reset addr"}, 32'(imem_addr), 32'd0);
    chk({tag, " R11 reset tos"}, tos, 32'd0);
    rst_n = 1'b1;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
      if (cyc > 2000) begin
        n_chk++; n_bad++;
        $display("FAIL %s watchdog actual=%0d expected=halt", tag, cyc);
        break;
      end
    end
    chk({tag, " R6 cycles to halt"}, 32'(cyc), 32'(e_pc + 1));
    chk({tag, " R6 halt addr"}, 32'(imem_addr), 32'(e_pc));
    chk({tag, " depth"}, 32'(depth), 32'(e_depth));
    chk({tag, " tos"}, tos, e_tos);
    chk({tag, " R8 R9 error"}, 32'(error), 32'(e_err));
    h_tos = tos; h_addr = imem_addr; h_depth = depth;
    repeat (5) @(negedge clk);
    chk({tag, " R10 frozen tos"}, tos, h_tos);
    chk({tag, " R10 frozen depth"}, 32'(depth), 32'(h_depth));
    chk({tag, " R10 frozen addr"}, 32'(imem_addr), 32'(h_addr));
    chk({tag, " R10 still halted"}, 32'(halted), 32'd1);
  endtask

  initial begin
    int p;
    int n;
    void'($urandom(32'd20240611));
    clear_mem();
    repeat (3) @(negedge clk);

    clear_mem();
    mem[0] = 8'h06; mem[1] = 8'h10; mem[2] = 8'h06; mem[3] = 8'h60;
    mem[4] = 8'h11; mem[5] = 8'h00; mem[6] = 8'h82; mem[7] = 8'h60;
    run_prog("R12 example");
    chk("R12 sum is 139", tos, 32'd139);
    chk("R12 depth one", 32'(depth), 32'd1);

    clear_mem();
    for (int i = 0; i < 6; i++) mem[i] = 8'(8'h03 + i);
    run_prog("R2 constants");
    chk("R2 top is 5", tos, 32'd5);

    clear_mem();
    mem[0] = 8'h10; mem[1] = 8'h80;
    run_prog("R3 byte push");
    chk("R3 sign-extended 0x80", tos, 32'hFFFF_FF80);

    clear_mem();
    mem[0] = 8'h11; mem[1] = 8'h80; mem[2] = 8'h00;
    mem[3] = 8'h11; mem[4] = 8'h7F; mem[5] = 8'hFF;
    run_prog("R4 short push");
    chk("R4 positive short", tos, 32'h0000_7FFF);

    clear_mem();
    mem[0] = 8'h11; mem[1] = 8'h80; mem[2] = 8'h00;
    run_prog("R4 negative short");
    chk("R4 sign-extended 0x8000", tos, 32'hFFFF_8000);

    clear_mem();
    mem[0] = 8'h10; mem[1] = 8'hFF; mem[2] = 8'h04; mem[3] = 8'h60;
    run_prog("R5 wrap add");
    chk("R5 wrap to zero", tos, 32'd0);

    clear_mem();
    for (int i = 0; i < 17; i++) mem[i] = 8'h05;
    run_prog("R8 overflow");
    chk("R8 error set", 32'(error), 32'd1);
    chk("R8 depth held", 32'(depth), 32'd16);
    chk("R8 addr on op", 32'(imem_addr), 32'd16);

    clear_mem();
    mem[0] = 8'h03; mem[1] = 8'h60;
    run_prog("R9 underflow");
    chk("R9 error set", 32'(error), 32'd1);
    chk("R9 depth held", 32'(depth), 32'd1);

    clear_mem();
    mem[0] = 8'h00;
    run_prog("R7 bad opcode");
    chk("R7 no error", 32'(error), 32'd0);
    chk("R11 empty tos", tos, 32'd0);

    for (int t = 0; t < 40; t++) begin
      clear_mem();
      p = 0;
      n = 1 + int'($urandom % 40);
      for (int k = 0; k < n; k++) begin
        case ($urandom % 9)
          0, 1, 2: begin mem[p] = 8'(8'h03 + ($urandom % 6)); p += 1; end
          3: begin mem[p] = 8'h10; mem[p+1] = 8'($urandom); p += 2; end
          4: begin mem[p] = 8'h11; mem[p+1] = 8'($urandom); mem[p+2] = 8'($urandom); p += 3; end
          5, 6, 7: begin mem[p] = 8'h60; p += 1; end
          default: begin mem[p] = 8'($urandom); p += 1; end
        endcase
      end
      run_prog("R2 R3 R4 R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL global watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule